// File: doc/BRIEF.md
# Instruction Pair Fusion Detector

This block looks at two decoded instructions that follow each other in program order and decides, once per clock, whether they can be merged into a single micro-operation. A merged operation takes one pass through the ALU. Each instruction arrives as a reduced decoded record: a class code, its source register numbers, a destination register number, an immediate flag with an immediate value, and an operand size.

A pair is merged only under three conditions. The two instructions must write the same register. The first one must not use the ALU: either a plain register copy, or a short immediate load that the decoder has already sign-extended. The combined effect must match an entry in a small table of operations that the ALU already implements.

When a merge is possible, the block reports a fused operation code together with one register source, one immediate operand and the shared destination, and it consumes both slots. Otherwise it issues the first instruction alone. The second instruction then moves up to become the older slot of the next pair. All results are registered, so they appear one clock after the pair is presented.

Top module: `fuse_pair_detector`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is driven to zero after that edge, whatever the input records hold.
- R2: The outputs after a rising edge are the decision for the pair presented at that edge. The latency is exactly one clock.
- R3: A pair whose destination register numbers differ never fuses.
- R4: A long register copy (class 1, immediate flag 0, source S, destination D), followed by a long half-word swap (class 4, immediate flag 0) that reads D in its first source and writes D, fuses. The result is op 1, register source S, immediate 0, destination D.
- R5: A long register copy into D, followed by a long logical shift right (class 5) or left (class 6) that reads D in its first source, writes D and has immediate flag 1, fuses. The result is op 2 (right) or op 3 (left), register source S, immediate equal to the shift instruction's immediate value, destination D. A shift whose count comes from a register (immediate flag 0) does not fuse.
- R6: A long quick immediate load (class 2, immediate flag 1, value V) into D, followed by a long XOR (class 7), AND (class 8) or OR (class 9), fuses when the second instruction meets all of these: immediate flag 0, writes D, and reads D in exactly one of its two sources. The result is op 4, 5 or 6 respectively, with the other source register, immediate V and destination D.
- R7: A pair whose first instruction is anything other than a register copy or a quick immediate load never fuses. This includes first instructions that themselves need the ALU: swap, shifts, XOR, AND, OR, add (class 10) and subtract (class 11).
- R8: A sign-extending move whose extension is done in the ALU (class 3) never fuses with the instruction after it.
- R9: Every combination not covered by R4 to R6 does not fuse. Examples: a wrong immediate flag on either instruction, a second instruction that does not read the first one's result in the allowed position, or a second class not in the table.
- R10: Fusion requires both instructions to have size code 2 (long).
- R11: When not fused, `fuse_o` is 0, the op, source, immediate and destination outputs are 0, and `take_o` is 1 if the older slot is valid and 0 otherwise. When fused, `take_o` is 2. A pair with either slot invalid never fuses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_valid | input | 1 | Older slot holds an instruction |
| a_cls | input | 4 | Older slot class code |
| a_imm | input | 1 | Older slot has an immediate operand |
| a_size | input | 2 | Older slot size (0 byte, 1 word, 2 long) |
| a_src | input | REG_W | Older slot source register |
| a_dst | input | REG_W | Older slot destination register |
| a_immv | input | IMM_W | Older slot immediate value |
| b_valid | input | 1 | Younger slot holds an instruction |
| b_cls | input | 4 | Younger slot class code |
| b_imm | input | 1 | Younger slot has an immediate operand |
| b_size | input | 2 | Younger slot size |
| b_src0 | input | REG_W | Younger slot first source register |
| b_src1 | input | REG_W | Younger slot second source register |
| b_dst | input | REG_W | Younger slot destination register |
| b_immv | input | IMM_W | Younger slot immediate value |
| fuse_o | output | 1 | Pair merged into one operation |
| op_o | output | 4 | Fused operation code (0 when not fused) |
| src_o | output | REG_W | Fused register source |
| imm_o | output | IMM_W | Fused immediate operand |
| dst_o | output | REG_W | Fused destination |
| take_o | output | 2 | Slots consumed this decision (0, 1 or 2) |

## Verification
The assertions guard, on every cycle, the properties that must hold for any fused result. They check that the destinations matched, that the first instruction was a copy or a quick load and never an ALU-extended move, and that both sizes were long. They also check the take count in both the fused and unfused cases. Whether the correct table entry, register source and immediate were chosen can only be shown by the bench. The bench compares each decision against its reference over an exhaustive sweep of class pairs and immediate flags, over random records with clustered register numbers, and over directed pairs drawn from the copy-then-swap, copy-then-shift and load-then-logic cases.

// File: rtl/fuse_pkg.sv
// Shared encodings for the pair fusion detector.
// Assumes: class codes come from an upstream decoder; fused op codes are
// consumed by the ALU issue logic.
package fuse_pkg;

    localparam int CLS_W = 4;
    localparam int FOP_W = 4;
    localparam logic [1:0] SZ_LONG = 2'b10;

    typedef enum logic [CLS_W-1:0] {
        CLS_NONE = 4'd0,
        CLS_COPY = 4'd1,   // register to register move
        CLS_QIMM = 4'd2,   // quick immediate load, extended in decode
        CLS_MVS  = 4'd3,   // sign-extending move, extended in the ALU
        CLS_SWAP = 4'd4,
        CLS_LSR  = 4'd5,
        CLS_LSL  = 4'd6,
        CLS_XOR  = 4'd7,
        CLS_AND  = 4'd8,
        CLS_OR   = 4'd9,
        CLS_ADD  = 4'd10,
        CLS_SUB  = 4'd11
    } cls_e;

    typedef enum logic [FOP_W-1:0] {
        FOP_NONE    = 4'd0,
        FOP_CP_SWAP = 4'd1,
        FOP_CP_LSR  = 4'd2,
        FOP_CP_LSL  = 4'd3,
        FOP_QI_XOR  = 4'd4,
        FOP_QI_AND  = 4'd5,
        FOP_QI_OR   = 4'd6
    } fop_e;

    localparam int FOP_COUNT = 16;
    localparam int FOP_LAST  = 6;

endpackage

// File: rtl/fuse_rule_check.sv
// Legality rules for merging two adjacent instructions.
// Produces a candidate fused op and its operands, with no validity or table
// filtering. Assumes the register fields of unused operands are don't-care.
module fuse_rule_check
    import fuse_pkg::*;
#(
    parameter int REG_W = 4,
    parameter int IMM_W = 8
) (
    input  logic [CLS_W-1:0] a_cls,
    input  logic             a_imm,
    input  logic [1:0]       a_size,
    input  logic [REG_W-1:0] a_src,
    input  logic [REG_W-1:0] a_dst,
    input  logic [IMM_W-1:0] a_immv,
    input  logic [CLS_W-1:0] b_cls,
    input  logic             b_imm,
    input  logic [1:0]       b_size,
    input  logic [REG_W-1:0] b_src0,
    input  logic [REG_W-1:0] b_src1,
    input  logic [REG_W-1:0] b_dst,
    input  logic [IMM_W-1:0] b_immv,
    output logic [FOP_W-1:0] cand_op,
    output logic [REG_W-1:0] cand_src,
    output logic [IMM_W-1:0] cand_imm
);

    logic shape_ok;
    logic rd0;
    logic rd1;

    // Shared preconditions: one common destination, long size on both.
    always_comb begin
        shape_ok = (a_size == SZ_LONG) && (b_size == SZ_LONG) && (a_dst == b_dst);
        rd0      = (b_src0 == a_dst);
        rd1      = (b_src1 == a_dst);
    end

    // Pattern match: a copy or decode-extended load feeding one ALU op.
    always_comb begin
        cand_op  = FOP_NONE;
        cand_src = '0;
        cand_imm = '0;
        if (shape_ok && (a_cls == CLS_COPY) && !a_imm && rd0) begin
            case (b_cls)
                CLS_SWAP: if (!b_imm) begin
                    cand_op  = FOP_CP_SWAP;
                    cand_src = a_src;
                end
                CLS_LSR: if (b_imm) begin
                    cand_op  = FOP_CP_LSR;
                    cand_src = a_src;
                    cand_imm = b_immv;
                end
                CLS_LSL: if (b_imm) begin
                    cand_op  = FOP_CP_LSL;
                    cand_src = a_src;
                    cand_imm = b_immv;
                end
                default: ;
            endcase
        end else if (shape_ok && (a_cls == CLS_QIMM) && a_imm && !b_imm && (rd0 != rd1)) begin
            case (b_cls)
                CLS_XOR: cand_op = FOP_QI_XOR;
                CLS_AND: cand_op = FOP_QI_AND;
                CLS_OR:  cand_op = FOP_QI_OR;
                default: cand_op = FOP_NONE;
            endcase
            if (cand_op != FOP_NONE) begin
                cand_src = rd0 ? b_src1 : b_src0;
                cand_imm = a_immv;
            end
        end
    end

endmodule

// File: rtl/fuse_op_table.sv
// Table of fused operations the ALU implements.
// SUPPORT_MASK bit n enables fused op code n; codes past the defined set and
// code 0 are never legal. Assumes a purely combinational lookup.
module fuse_op_table
    import fuse_pkg::*;
#(
    parameter logic [FOP_COUNT-1:0] SUPPORT_MASK = 16'h007E
) (
    input  logic [FOP_W-1:0] op_i,
    output logic             ok_o
);

    logic [FOP_COUNT-1:0] supported;

    // One table entry per code: enabled by the mask and inside the defined set.
    for (genvar g = 0; g < FOP_COUNT; g++) begin : g_entry
        if (g >= 1 && g <= FOP_LAST) begin : g_def
            assign supported[g] = SUPPORT_MASK[g];
        end else begin : g_undef
            assign supported[g] = 1'b0;
        end
    end

    // Lookup of the candidate code.
    assign ok_o = supported[op_i];

endmodule

// File: rtl/fuse_pair_detector.sv
// Top of the pair fusion detector.
// Combines the legality rules with the supported-op table, gates with slot
// validity, and registers the decision. Assumes slot A is older in program
// order; when not fused only slot A issues.
module fuse_pair_detector
    import fuse_pkg::*;
#(
    parameter int REG_W = 4,
    parameter int IMM_W = 8,
    parameter logic [FOP_COUNT-1:0] SUPPORT_MASK = 16'h007E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_valid,
    input  logic [CLS_W-1:0] a_cls,
    input  logic             a_imm,
    input  logic [1:0]       a_size,
    input  logic [REG_W-1:0] a_src,
    input  logic [REG_W-1:0] a_dst,
    input  logic [IMM_W-1:0] a_immv,
    input  logic             b_valid,
    input  logic [CLS_W-1:0] b_cls,
    input  logic             b_imm,
    input  logic [1:0]       b_size,
    input  logic [REG_W-1:0] b_src0,
    input  logic [REG_W-1:0] b_src1,
    input  logic [REG_W-1:0] b_dst,
    input  logic [IMM_W-1:0] b_immv,
    output logic             fuse_o,
    output logic [FOP_W-1:0] op_o,
    output logic [REG_W-1:0] src_o,
    output logic [IMM_W-1:0] imm_o,
    output logic [REG_W-1:0] dst_o,
    output logic [1:0]       take_o
);

    logic [FOP_W-1:0] cand_op;
    logic [REG_W-1:0] cand_src;
    logic [IMM_W-1:0] cand_imm;
    logic             tbl_ok;
    logic             pair_ok;

    fuse_rule_check #(.REG_W(REG_W), .IMM_W(IMM_W)) u_rules (
        .a_cls(a_cls), .a_imm(a_imm), .a_size(a_size), .a_src(a_src),
        .a_dst(a_dst), .a_immv(a_immv),
        .b_cls(b_cls), .b_imm(b_imm), .b_size(b_size), .b_src0(b_src0),
        .b_src1(b_src1), .b_dst(b_dst), .b_immv(b_immv),
        .cand_op(cand_op), .cand_src(cand_src), .cand_imm(cand_imm)
    );

    fuse_op_table #(.SUPPORT_MASK(SUPPORT_MASK)) u_table (
        .op_i(cand_op),
        .ok_o(tbl_ok)
    );

    // Final merge decision: both slots present and a supported candidate.
    always_comb begin
        pair_ok = a_valid && b_valid && tbl_ok;
    end

    // Decision register: zero in reset, otherwise the fused or single issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fuse_o <= 1'b0;
            op_o   <= '0;
            src_o  <= '0;
            imm_o  <= '0;
            dst_o  <= '0;
            take_o <= 2'd0;
        end else begin
            fuse_o <= pair_ok;
            op_o   <= pair_ok ? cand_op  : '0;
            src_o  <= pair_ok ? cand_src : '0;
            imm_o  <= pair_ok ? cand_imm : '0;
            dst_o  <= pair_ok ? a_dst    : '0;
            take_o <= pair_ok ? 2'd2 : (a_valid ? 2'd1 : 2'd0);
        end
    end

    // A fused result always came from one shared destination (R3).
    p_shared_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_o |-> ($past(a_dst) == $past(b_dst)) && (dst_o == $past(a_dst)));

    // The older instruction of a fused pair never used the ALU (R7).
    p_first_no_alu_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_o |-> ($past(a_cls) == CLS_COPY) || ($past(a_cls) == CLS_QIMM));

    // An ALU-extended move is never the older half of a fused pair (R8).
    p_alu_ext_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_o |-> ($past(a_cls) != CLS_MVS));

    // Both halves of a fused pair were long (R10).
    p_long_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_o |-> ($past(a_size) == SZ_LONG) && ($past(b_size) == SZ_LONG));

    // Fused decisions consume two slots and had both slots valid (R11).
    p_fused_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_o |-> (take_o == 2'd2) && $past(a_valid) && $past(b_valid) && (op_o != FOP_NONE));

    // Unfused decisions issue only the older slot and clear the op (R11).
    p_single_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!fuse_o && $past(rst_n)) |-> (op_o == FOP_NONE) && (take_o == {1'b0, $past(a_valid)}));

endmodule

// File: tb/fuse_pair_detector_tb.sv
// Bench for the pair fusion detector: exhaustive class sweep, constrained
// random records and directed pairs against a reference built from the rules.
module fuse_pair_detector_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int REG_W = 4;
    localparam int IMM_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             a_valid, a_imm, b_valid, b_imm;
    logic [3:0]       a_cls, b_cls;
    logic [1:0]       a_size, b_size;
    logic [REG_W-1:0] a_src, a_dst, b_src0, b_src1, b_dst;
    logic [IMM_W-1:0] a_immv, b_immv;
    logic             fuse_o;
    logic [3:0]       op_o;
    logic [REG_W-1:0] src_o, dst_o;
    logic [IMM_W-1:0] imm_o;
    logic [1:0]       take_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fuse_pair_detector #(.REG_W(REG_W), .IMM_W(IMM_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_valid(a_valid), .a_cls(a_cls), .a_imm(a_imm), .a_size(a_size),
        .a_src(a_src), .a_dst(a_dst), .a_immv(a_immv),
        .b_valid(b_valid), .b_cls(b_cls), .b_imm(b_imm), .b_size(b_size),
        .b_src0(b_src0), .b_src1(b_src1), .b_dst(b_dst), .b_immv(b_immv),
        .fuse_o(fuse_o), .op_o(op_o), .src_o(src_o), .imm_o(imm_o),
        .dst_o(dst_o), .take_o(take_o)
    );

    // Reference decision written from the requirement text.
    function automatic void ref_decide(output bit f, output logic [3:0] op,
                                       output logic [REG_W-1:0] s, output logic [IMM_W-1:0] im,
                                       output logic [REG_W-1:0] d, output logic [1:0] tk,
                                       output string tag);
        bit r0, r1;
        f = 0; op = 0; s = 0; im = 0; d = 0; tag = "R11";
        tk = a_valid ? 2'd1 : 2'd0;
        r0 = (b_src0 == a_dst);
        r1 = (b_src1 == a_dst);
        if (a_valid && b_valid) begin
            if (a_size != 2 || b_size != 2) tag = "R10";
            else if (a_dst != b_dst) tag = "R3";
            else if (a_cls == 3) tag = "R8";
            else if (a_cls != 1 && a_cls != 2) tag = "R7";
            else if (a_cls == 1) begin
                tag = "R9";
                if (!a_imm && r0 && b_cls == 4 && !b_imm) begin
                    f = 1; op = 1; s = a_src; tag = "R4";
                end else if (!a_imm && r0 && (b_cls == 5 || b_cls == 6) && b_imm) begin
                    f = 1; op = (b_cls == 5) ? 4'd2 : 4'd3; s = a_src; im = b_immv; tag = "R5";
                end
            end else begin
                tag = "R9";
                if (a_imm && !b_imm && (r0 ^ r1) && b_cls >= 7 && b_cls <= 9) begin
                    f = 1; op = b_cls - 4'd3; s = r0 ? b_src1 : b_src0; im = a_immv; tag = "R6";
                end
            end
        end
        if (f) begin d = a_dst; tk = 2'd2; end
    endfunction

    task automatic report(input string tag, input bit ok, input string got, input string exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %s expected %s", tag, got, exp);
        end
    endtask

    // Apply current inputs across one edge and compare at the following low phase.
    task automatic step_check(input string extra);
        bit ef; logic [3:0] eop; logic [REG_W-1:0] es, ed; logic [IMM_W-1:0] ei;
        logic [1:0] etk; string tag;
        ref_decide(ef, eop, es, ei, ed, etk, tag);
        @(posedge clk);
        @(negedge clk);
        report({tag, extra}, (fuse_o == ef) && (op_o == eop) && (src_o == es) &&
               (imm_o == ei) && (dst_o == ed) && (take_o == etk),
               $sformatf("f=%0d op=%0d s=%0d i=%0d d=%0d t=%0d", fuse_o, op_o, src_o, imm_o, dst_o, take_o),
               $sformatf("f=%0d op=%0d s=%0d i=%0d d=%0d t=%0d", ef, eop, es, ei, ed, etk));
    endtask

    task automatic set_a(input bit v, input int c, input bit im, input int sz,
                         input int s, input int d, input int iv);
        a_valid = v; a_cls = 4'(c); a_imm = im; a_size = 2'(sz);
        a_src = REG_W'(s); a_dst = REG_W'(d); a_immv = IMM_W'(iv);
    endtask

    task automatic set_b(input bit v, input int c, input bit im, input int sz,
                         input int s0, input int s1, input int d, input int iv);
        b_valid = v; b_cls = 4'(c); b_imm = im; b_size = 2'(sz);
        b_src0 = REG_W'(s0); b_src1 = REG_W'(s1); b_dst = REG_W'(d); b_immv = IMM_W'(iv);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        void'($urandom(32'h0F05E));
        // R1: reset dominates a fusable pair.
        set_a(1, 1, 0, 2, 5, 1, 0);
        set_b(1, 4, 0, 2, 1, 0, 1, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        report("R1", {fuse_o, op_o, src_o, imm_o, dst_o, take_o} == '0,
               $sformatf("%0h", {fuse_o, op_o, src_o, imm_o, dst_o, take_o}), "0");
        rst_n = 1'b1;

        // Directed: copy then swap (R4), copy then shift by 8 (R5), R2 latency.
        step_check(" R2 copy+swap");
        set_b(1, 5, 1, 2, 1, 0, 1, 8);  step_check(" copy+lsr8");
        set_b(1, 6, 1, 2, 1, 0, 1, 3);  step_check(" copy+lsl3");
        set_b(1, 5, 0, 2, 1, 2, 1, 0);  step_check(" register count");
        // Quick load then logic op writing the same register (R6).
        set_a(1, 2, 1, 2, 0, 0, 7);
        set_b(1, 7, 0, 2, 1, 0, 0, 0);  step_check(" qimm+xor");
        set_b(1, 8, 0, 2, 0, 3, 0, 0);  step_check(" qimm+and");
        set_b(1, 9, 0, 2, 2, 0, 0, 0);  step_check(" qimm+or");
        set_b(1, 7, 0, 2, 0, 0, 0, 0);  step_check(" R9 both read dst");
        // Quick load writes a different register than the op (R3).
        set_b(1, 7, 0, 2, 1, 0, 1, 0);  step_check(" split dst");
        // Two ALU ops (R7) and ALU-extended move (R8).
        set_a(1, 10, 0, 2, 0, 1, 0); set_b(1, 4, 0, 2, 1, 0, 1, 0); step_check(" add+swap");
        set_a(1, 7, 0, 2, 0, 1, 0);  step_check(" xor+swap");
        set_a(1, 3, 0, 2, 0, 1, 0);  set_b(1, 7, 0, 2, 1, 2, 1, 0); step_check(" mvs+xor");
        // Word size (R10) and invalid slots (R11).
        set_a(1, 1, 0, 1, 5, 1, 0); set_b(1, 4, 0, 2, 1, 0, 1, 0); step_check(" word copy");
        set_a(1, 1, 0, 2, 5, 1, 0); set_b(0, 4, 0, 2, 1, 0, 1, 0); step_check(" b invalid");
        set_a(0, 1, 0, 2, 5, 1, 0); step_check(" a invalid");

        // Exhaustive sweep over class pairs, immediate flags and read position.
        for (int ca = 0; ca < 12; ca++)
            for (int cb = 0; cb < 12; cb++)
                for (int fl = 0; fl < 4; fl++)
                    for (int rp = 0; rp < 2; rp++) begin
                        set_a(1, ca, fl[0], 2, 6, 2, 9);
                        if (rp == 0) set_b(1, cb, fl[1], 2, 2, 5, 2, 4);
                        else         set_b(1, cb, fl[1], 2, 5, 2, 2, 4);
                        step_check(" sweep");
                    end

        // Constrained random: clustered registers, mostly long, mostly valid.
        for (int i = 0; i < 4000; i++) begin
            set_a(($urandom % 8) != 0, ($urandom % 3 == 0) ? $urandom % 12 : 1 + $urandom % 2,
                  $urandom % 2, ($urandom % 5 == 0) ? $urandom % 4 : 2,
                  $urandom % 4, $urandom % 4, $urandom % 256);
            set_b(($urandom % 8) != 0, $urandom % 12, $urandom % 2,
                  ($urandom % 5 == 0) ? $urandom % 4 : 2,
                  $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 256);
            step_check(" random");
        end

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule